// File: doc/BRIEF.md
# Memory Sleep Phase Controller

This block sequences a synchronous memory into and out of a low-power sleep state. The request for sleep arrives on a pin that has no timing relation to the memory clock. It is passed through a flop synchroniser before any logic uses it. From the synchronised edge the controller runs a fixed entry window and then holds the memory asleep. When the request is withdrawn, it runs a fixed recovery window before access is allowed again. The stored array is never touched by this block, so its contents survive the sleep period.

The memory core uses `access_en` to gate every read and write. The controller drops it on the first entry cycle and raises it again only after recovery has finished. Any access still in progress when entry begins is abandoned. The block also watches the host's chip enables and address strobes. It raises one-cycle violation pulses when the host breaks the sleep protocol: when it selects the device or strobes an address during recovery, or when it asks for sleep while the device is still selected.

Top module: `slumber_ctrl`

## Requirements
- R1: After reset, `access_en` is 1 and `asleep`, `recov_busy`, `viol_recov` and `viol_sel` are all 0.
- R2: The request passes through SYNC_STAGES (2) flops before it is used. Raising `sleep_req_a` between clock edges makes `access_en` fall at the third rising edge after the change, and not before.
- R3: The entry phase lasts WIN_CYC (2) cycles. During entry, `access_en`, `asleep` and `recov_busy` are all 0, and `asleep` rises at the end of entry.
- R4: Lowering `sleep_req_a` while asleep makes `recov_busy` rise at the third rising edge after the change. `recov_busy` then stays high for exactly WIN_CYC (2) cycles, and `access_en` returns to 1 when it falls.
- R5: `access_en` stays 0 from the first entry cycle until recovery completes. At most one of `access_en`, `asleep` and `recov_busy` is 1 at any time.
- R6: `viol_recov` is 1 for one cycle after a recovery cycle in which any bit of `sel_en` or `adr_stb` was 1. Strobes seen while awake or asleep never set it.
- R7: `viol_sel` is 1 for one cycle, on the cycle entry begins, if any bit of `sel_en` was 1 when the synchronised request started entry. Entry still proceeds, and the pending access is dropped.
- R8: If the request is withdrawn before entry completes, `asleep` never rises, and the controller runs a full WIN_CYC-cycle recovery before `access_en` returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_req_a | input | 1 | Sleep request, asynchronous to `clk`, active high |
| sel_en | input | NSEL | Host chip enables, decoded to active high |
| adr_stb | input | NSTB | Host address strobes, decoded to active high |
| access_en | output | 1 | Internal access enable for the memory core |
| asleep | output | 1 | Memory is in sleep |
| recov_busy | output | 1 | Recovery window in progress |
| viol_recov | output | 1 | Pulse: host selected or strobed during recovery |
| viol_sel | output | 1 | Pulse: sleep entry began while the device was selected |

## Verification
The hardest state to reach from the ports is the aborted entry. The request has to be high for long enough to pass the synchroniser, and then low again before the entry window closes. The bench holds the request high for exactly one cycle, so the synchronised pulse is one cycle wide. That pulse starts entry and is gone by the next edge, which forces the controller from entry straight into recovery. The recovery-violation check is aimed the same way: a strobe is placed in the first recovery cycle, a timing found by counting edges from the release of the request.

// File: rtl/slumber_pkg.sv
// Package: shared phase encoding for the sleep controller.
// Assumes: nothing beyond a single clock domain for its users.
package slumber_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_ENTER = 2'd1,
        ST_SLEEP = 2'd2,
        ST_RECOV = 2'd3
    } slp_phase_t;

endpackage

// File: rtl/slumber_sync.sv
// Module: multi-flop synchroniser for one asynchronous level.
// Assumes: input is a slow level (held for more than one clock);
// output resets low.
module slumber_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_a,
    output logic dout
);

    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // capture the raw asynchronous level
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din_a;
                end
            end else begin : g_next
                // shift towards the synchronised output
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/slumber_fsm.sv
// Module: phase sequencer for awake -> entry -> sleep -> recovery.
// Assumes: req_s is already synchronised; both windows are WIN_CYC
// cycles long; a request withdrawn during entry goes to recovery.
module slumber_fsm
    import slumber_pkg::*;
#(
    parameter int WIN_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    output slp_phase_t phase
);

    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt;

    // advance the phase and the window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_AWAKE;
            cnt   <= '0;
        end else begin
            case (phase)
                ST_AWAKE: begin
                    if (req_s) begin
                        phase <= ST_ENTER;
                        cnt   <= '0;
                    end
                end
                ST_ENTER: begin
                    if (!req_s) begin
                        phase <= ST_RECOV;
                        cnt   <= '0;
                    end else if (cnt == LAST) begin
                        phase <= ST_SLEEP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SLEEP: begin
                    if (!req_s) begin
                        phase <= ST_RECOV;
                        cnt   <= '0;
                    end
                end
                default: begin
                    if (cnt == LAST) phase <= ST_AWAKE;
                    else             cnt   <= cnt + 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/slumber_viol.sv
// Module: host protocol watcher for the sleep sequence.
// Assumes: sel_en/adr_stb are active high; flags are one-cycle pulses.
module slumber_viol
    import slumber_pkg::*;
#(
    parameter int NSEL = 3,
    parameter int NSTB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  slp_phase_t      phase,
    input  logic            req_s,
    input  logic [NSEL-1:0] sel_en,
    input  logic [NSTB-1:0] adr_stb,
    output logic            viol_recov,
    output logic            viol_sel
);

    logic host_busy;
    assign host_busy = (|sel_en) || (|adr_stb);

    // register both protocol flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_recov <= 1'b0;
            viol_sel   <= 1'b0;
        end else begin
            viol_recov <= (phase == ST_RECOV) && host_busy;
            viol_sel   <= (phase == ST_AWAKE) && req_s && (|sel_en);
        end
    end

endmodule

// File: rtl/slumber_ctrl.sv
// Module: top of the memory sleep controller.
// Assumes: sleep_req_a is asynchronous; all other inputs are sync to clk.
module slumber_ctrl
    import slumber_pkg::*;
#(
    parameter int NSEL        = 3,
    parameter int NSTB        = 2,
    parameter int SYNC_STAGES = 2,
    parameter int WIN_CYC     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req_a,
    input  logic [NSEL-1:0] sel_en,
    input  logic [NSTB-1:0] adr_stb,
    output logic            access_en,
    output logic            asleep,
    output logic            recov_busy,
    output logic            viol_recov,
    output logic            viol_sel
);

    logic       req_s;
    slp_phase_t phase;

    slumber_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din_a (sleep_req_a),
        .dout  (req_s)
    );

    slumber_fsm #(.WIN_CYC(WIN_CYC)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req_s (req_s),
        .phase (phase)
    );

    slumber_viol #(.NSEL(NSEL), .NSTB(NSTB)) u_viol (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .req_s      (req_s),
        .sel_en     (sel_en),
        .adr_stb    (adr_stb),
        .viol_recov (viol_recov),
        .viol_sel   (viol_sel)
    );

    // decode the phase into status and gating outputs
    always_comb begin
        access_en  = (phase == ST_AWAKE);
        asleep     = (phase == ST_SLEEP);
        recov_busy = (phase == ST_RECOV);
    end

endmodule

// File: rtl/slumber_ctrl_chk.sv
// Module: property checker bound to slumber_ctrl, port-level only.
// Assumes: window lengths are counted by local counters, not $past depth.
module slumber_ctrl_chk #(
    parameter int NSEL    = 3,
    parameter int NSTB    = 2,
    parameter int WIN_CYC = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSEL-1:0] sel_en,
    input logic [NSTB-1:0] adr_stb,
    input logic            access_en,
    input logic            asleep,
    input logic            recov_busy,
    input logic            viol_recov,
    input logic            viol_sel
);

    localparam int KW = $clog2(WIN_CYC + 2) + 1;

    logic [KW-1:0] ent_cnt;
    logic [KW-1:0] rec_cnt;
    logic          entering;

    assign entering = !access_en && !asleep && !recov_busy;

    // count consecutive entry and recovery cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_cnt <= '0;
            rec_cnt <= '0;
        end else begin
            ent_cnt <= entering   ? ent_cnt + 1'b1 : '0;
            rec_cnt <= recov_busy ? rec_cnt + 1'b1 : '0;
        end
    end

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({access_en, asleep, recov_busy})); // R5

    AST_ENTRY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> (ent_cnt == KW'(WIN_CYC))); // R3

    AST_RECOV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(recov_busy) |-> (rec_cnt == KW'(WIN_CYC)) && access_en); // R4

    AST_ACCESS_AFTER_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_en) |-> $past(recov_busy)); // R5

    AST_VIOL_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
        (recov_busy && ((|sel_en) || (|adr_stb))) |=> viol_recov); // R6

    AST_VIOL_ONLY_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
        viol_recov |-> $past(recov_busy)); // R6

    AST_VIOL_SEL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        viol_sel |-> entering && $past(access_en)); // R7

endmodule

bind slumber_ctrl slumber_ctrl_chk #(
    .NSEL    (NSEL),
    .NSTB    (NSTB),
    .WIN_CYC (WIN_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_en     (sel_en),
    .adr_stb    (adr_stb),
    .access_en  (access_en),
    .asleep     (asleep),
    .recov_busy (recov_busy),
    .viol_recov (viol_recov),
    .viol_sel   (viol_sel)
);

// File: tb/slumber_ctrl_tb.sv
// Directed bench for slumber_ctrl; inputs change on the falling edge,
// outputs are sampled on the falling edge.
module slumber_ctrl_tb;

    localparam int NSEL = 3;
    localparam int NSTB = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sleep_req_a = 1'b0;
    logic [NSEL-1:0] sel_en = '0;
    logic [NSTB-1:0] adr_stb = '0;
    logic            access_en, asleep, recov_busy, viol_recov, viol_sel;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    slumber_ctrl #(.NSEL(NSEL), .NSTB(NSTB)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req_a (sleep_req_a),
        .sel_en      (sel_en),
        .adr_stb     (adr_stb),
        .access_en   (access_en),
        .asleep      (asleep),
        .recov_busy  (recov_busy),
        .viol_recov  (viol_recov),
        .viol_sel    (viol_sel)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // compare {access_en, asleep, recov_busy, viol_recov, viol_sel}
    task automatic chk(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {access_en, asleep, recov_busy, viol_recov, viol_sel};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {en,slp,rec,vr,vs} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        chk("R1 reset", 5'b10000);
        rst_n = 1'b1;
        tick(1);
        chk("R1 after release", 5'b10000);
    endtask

    task automatic t_enter_exit();
        sleep_req_a = 1'b1;
        tick(2);
        chk("R2 still awake through sync", 5'b10000);
        tick(1);
        chk("R2 entry starts third edge", 5'b00000);
        tick(1);
        chk("R3 second entry cycle", 5'b00000);
        tick(1);
        chk("R3 asleep", 5'b01000);
        adr_stb = 2'b01;
        sel_en  = 3'b010;
        tick(1);
        chk("R6 strobe in sleep ignored", 5'b01000);
        adr_stb = '0;
        sel_en  = '0;
        sleep_req_a = 1'b0;
        tick(2);
        chk("R4 still asleep through sync", 5'b01000);
        tick(1);
        chk("R4 recovery starts", 5'b00100);
        tick(1);
        chk("R5 recovery second cycle", 5'b00100);
        tick(1);
        chk("R4 access restored", 5'b10000);
    endtask

    task automatic t_recov_viol();
        sleep_req_a = 1'b1;
        tick(5);
        chk("R3 asleep again", 5'b01000);
        sleep_req_a = 1'b0;
        tick(3);
        chk("R4 recovery first cycle", 5'b00100);
        adr_stb = 2'b10;
        tick(1);
        chk("R6 strobe in recovery flagged", 5'b00110);
        adr_stb = '0;
        tick(1);
        chk("R6 flag clears, access back", 5'b10000);
        adr_stb = 2'b11;
        tick(1);
        chk("R6 strobe while awake ignored", 5'b10000);
        adr_stb = '0;
    endtask

    task automatic t_sel_viol();
        sel_en = 3'b100;
        sleep_req_a = 1'b1;
        tick(3);
        chk("R7 selected at request", 5'b00001);
        sel_en = '0;
        tick(1);
        chk("R7 pulse one cycle, entry goes on", 5'b00000);
        tick(1);
        chk("R7 asleep despite violation", 5'b01000);
        sleep_req_a = 1'b0;
        tick(5);
        chk("R4 back awake", 5'b10000);
    endtask

    task automatic t_abort();
        sleep_req_a = 1'b1;
        tick(1);
        sleep_req_a = 1'b0;
        tick(2);
        chk("R8 short request enters", 5'b00000);
        tick(1);
        chk("R8 abort into recovery", 5'b00100);
        tick(1);
        chk("R8 full recovery window", 5'b00100);
        tick(1);
        chk("R8 access after recovery", 5'b10000);
        tick(3);
        chk("R8 never slept", 5'b10000);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_enter_exit();
        t_recov_viol();
        t_sel_viol();
        t_abort();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule